// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Word Holding Queue

This block recovers asynchronous NRZ frames from a single serial line and holds up to two finished words for a reader. The line is sampled once per pulse of `os_tick`, which the surrounding logic supplies at sixteen times the bit rate. A frame is one low start bit, then eight or nine data bits sent least significant bit first, then one high stop bit. Each bit is decided by a three-sample majority vote around the middle of its period, so that a single corrupted sample does not change the result.

Each finished word is written into a two-entry queue. Its framing-error flag and its ninth data bit are stored in the same entry as the data. The outputs always show the entry at the head of the queue. A one-cycle `rd_pop` pulse removes the head, and the data and status of the next entry then appear together. If a frame ends while both entries are occupied, that frame is dropped and a sticky overrun flag is raised. While the flag is set, no further word enters the queue. Pulling `rx_en` low clears the flag and returns the sampler to idle, but keeps the words already queued.

The bit engine has four states. `ST_IDLE` waits for a low sample. `ST_START` votes on the start bit and goes back to `ST_IDLE` on a false start; otherwise it moves to `ST_DATA` at the end of the bit period. `ST_DATA` moves to `ST_STOP` after the last data bit. `ST_STOP` votes on the stop bit, hands the frame over and goes back to `ST_IDLE`. Every state goes to `ST_IDLE` whenever `rx_en` is low.

Top module: `async_rx_fifo`

## Requirements
- R1: In idle, a tick that samples `rx_line` low is sample 0 of a start bit. On the tick that takes sample 9, the majority of samples 7, 8 and 9 decides the start bit: high means a false start, the receiver returns to idle, and nothing is queued.
- R2: Each data bit is the majority of samples 7, 8 and 9 of its 16-sample period. Bits arrive least significant bit first. With `nine_bit`=0 a frame carries 8 data bits and its stored ninth bit is 0.
- R3: With `nine_bit`=1 a frame carries 9 data bits. The last bit received is stored as the ninth bit and shown on `rx_bit9`.
- R4: A completed frame enters the queue when there is room and no overrun. `rx_avail` rises two clock edges after the tick that samples the stop bit's ninth sample. `rx_avail` stays high until every queued entry has been popped. A pop while the queue is empty has no effect.
- R5: `rx_ferr` of an entry is 1 when the stop-bit majority is low. `rx_data`, `rx_bit9` and `rx_ferr` all show the head entry and move together to the next entry on a pop.
- R6: When a frame completes while both entries are occupied (occupancy counted before any pop on that edge), `rx_ovr` is set, the frame is discarded, and both queued words are kept.
- R7: While `rx_ovr` is 1 and `rx_en` is 1, no frame enters the queue and `rx_ovr` stays set.
- R8: While `rx_en` is 0, the sampler stays idle and frames on the line are ignored. `rx_ovr` reads 0 from the edge after `rx_en` is sampled low, and the queued words are kept.
- R9: After reset, `rx_avail` and `rx_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Continuous receive enable; low clears overrun and idles sampler |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| rd_pop | input | 1 | Remove the head entry |
| rx_avail | output | 1 | Queue holds at least one word |
| rx_data | output | 8 | Data of the head entry |
| rx_bit9 | output | 1 | Ninth bit of the head entry |
| rx_ferr | output | 1 | Framing error of the head entry |
| rx_ovr | output | 1 | Sticky overrun flag |

## Verification
The bench drives the line one sample per tick. This lets it place a glitch on exactly one voting sample. A receiver that decided a bit from a single centre sample would then deliver wrong data, and one that voted on the wrong sample window would fail the start-bit test. A short low pulse checks false-start rejection: a design that skipped the start vote would queue a spurious word. A bad-stop frame followed by a good frame checks per-entry status. A design that kept one shared framing flag would report the error against the wrong word. Three frames with no reads, then a fourth frame, then an enable toggle check overrun. A design that overwrote an entry, accepted the fourth word, failed to clear the flag, or flushed the queue on the toggle would show the wrong head or the wrong `rx_avail`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    parameter int unsigned RX_DW = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic             ferr;
        logic             bit9;
        logic [RX_DW-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
    import rxq_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     tick,
    input  logic     line,
    input  logic     nine,
    output logic     frm_valid,
    output rx_word_t frm_word
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned BW = $clog2(RX_DW + 1);
    localparam logic [CW-1:0] V0   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] V1   = CW'(OSR / 2);
    localparam logic [CW-1:0] V2   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [BW-1:0]  last_bit;
    logic           v0, v1;
    logic [RX_DW:0] sh;
    logic           maj;

    assign maj      = (v0 & v1) | (v0 & line) | (v1 & line);
    assign last_bit = nine ? BW'(RX_DW) : BW'(RX_DW - 1);

    always_comb begin
        state_n = state;
        if (!run) begin
            state_n = ST_IDLE;
        end else if (tick) begin
            unique case (state)
                ST_IDLE:  if (!line) state_n = ST_START;
                ST_START: begin
                    if (cnt == V2 && maj)  state_n = ST_IDLE;
                    else if (cnt == LAST)  state_n = ST_DATA;
                end
                ST_DATA:  if (cnt == LAST && bitn == last_bit) state_n = ST_STOP;
                ST_STOP:  if (cnt == V2) state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bitn      <= '0;
            v0        <= 1'b1;
            v1        <= 1'b1;
            sh        <= '0;
            frm_valid <= 1'b0;
            frm_word  <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (!run) begin
                cnt  <= '0;
                bitn <= '0;
            end else if (tick) begin
                if (state == ST_IDLE) begin
                    cnt <= line ? '0 : CW'(1);
                end else begin
                    cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
                    if (cnt == V0) v0 <= line;
                    if (cnt == V1) v1 <= line;
                    if (state == ST_START && cnt == V2 && maj) cnt <= '0;
                    if (state == ST_START && cnt == LAST) bitn <= '0;
                    if (state == ST_DATA && cnt == V2) sh <= {maj, sh[RX_DW:1]};
                    if (state == ST_DATA && cnt == LAST) bitn <= bitn + BW'(1);
                    if (state == ST_STOP && cnt == V2) begin
                        frm_valid     <= 1'b1;
                        frm_word.data <= nine ? sh[RX_DW-1:0] : sh[RX_DW:1];
                        frm_word.bit9 <= nine & sh[RX_DW];
                        frm_word.ferr <= ~maj;
                        cnt           <= '0;
                    end
                end
            end
        end
    end

    // a finished frame is flagged for exactly one cycle
    assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    // no frame leaves the sampler unless receive was enabled on the edge before
    assert_frame_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> $past(run));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_word_t                   wr_word,
    input  logic                       pop,
    output rx_word_t                   head_word,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

    rx_word_t      mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok;

    assign pop_ok    = pop && (occ != '0);
    assign head_word = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_word;
                wr_ptr      <= (wr_ptr == PMAX) ? '0 : wr_ptr + PW'(1);
            end
            if (pop_ok) rd_ptr <= (rd_ptr == PMAX) ? '0 : rd_ptr + PW'(1);
            occ <= occ + OW'(push) - OW'(pop_ok);
        end
    end

    assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !push) |=> occ == '0);
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned OSR   = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             nine_bit,
    input  logic             os_tick,
    input  logic             rx_line,
    input  logic             rd_pop,
    output logic             rx_avail,
    output logic [RX_DW-1:0] rx_data,
    output logic             rx_bit9,
    output logic             rx_ferr,
    output logic             rx_ovr
);
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam logic [OW-1:0] FULL = OW'(DEPTH);

    logic          frm_valid;
    rx_word_t      frm_word, head;
    logic [OW-1:0] occ;
    logic          push, ovr_set, ovr_q;

    rx_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .run(rx_en), .tick(os_tick),
        .line(rx_line), .nine(nine_bit),
        .frm_valid(frm_valid), .frm_word(frm_word)
    );

    assign push    = frm_valid && rx_en && !ovr_q && (occ < FULL);
    assign ovr_set = frm_valid && rx_en && !ovr_q && (occ == FULL);

    rx_fifo #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_word(frm_word),
        .pop(rd_pop), .head_word(head), .occ(occ)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (!rx_en)  ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
    end

    assign rx_avail = (occ != '0);
    assign rx_data  = head.data;
    assign rx_bit9  = head.bit9;
    assign rx_ferr  = head.ferr;
    assign rx_ovr   = ovr_q;

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && rx_en) |=> ovr_q);

    assert_no_fill_on_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && rx_en) |=> occ <= $past(occ));

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !ovr_q);

    assert_avail_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail) |-> $past(rd_pop));

    assert_ovr_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(occ) == FULL);
endmodule

// File: tb/sim_async_rx_fifo.sv
module sim_async_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n, rx_en, nine_bit, os_tick, rx_line, rd_pop;
    logic       rx_avail, rx_bit9, rx_ferr, rx_ovr;
    logic [7:0] rx_data;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    bit  sampq[$];
    int  tdiv = 0;

    always #5 clk = ~clk;

    async_rx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
        .os_tick(os_tick), .rx_line(rx_line), .rd_pop(rd_pop),
        .rx_avail(rx_avail), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // line player: one queued sample per tick, tick every 4 clocks
    initial begin
        os_tick = 1'b0;
        rx_line = 1'b1;
    end
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % 4;
        os_tick = (tdiv == 0);
        if (os_tick) rx_line = (sampq.size() > 0) ? sampq.pop_front() : 1'b1;
    end

    // behavioural reference model
    int          ms, mpos, mnb, mbk, mj, msz;
    bit          cur[16];
    bit [8:0]    macc;
    bit          mpend, m_ovr, popok, dopush, doovr;
    logic [10:0] mword;
    logic [10:0] mq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mpend = 0; m_ovr = 0; mq.delete();
        end else begin
            msz    = mq.size();
            popok  = rd_pop && msz > 0;
            dopush = mpend && rx_en && !m_ovr && msz < 2;
            doovr  = mpend && rx_en && !m_ovr && msz == 2;
            if (popok)  void'(mq.pop_front());
            if (dopush) mq.push_back(mword);
            if (!rx_en) m_ovr = 0;
            else if (doovr) m_ovr = 1;
            mpend = 0;
            if (!rx_en) ms = 0;
            else if (os_tick) begin
                if (ms == 0) begin
                    if (!rx_line) begin ms = 1; mpos = 1; mnb = nine_bit ? 9 : 8; end
                end else begin
                    mbk = mpos / 16;
                    cur[mpos % 16] = rx_line;
                    if (mpos % 16 == 9) begin
                        mj = ((int'(cur[7]) + int'(cur[8]) + int'(cur[9])) >= 2) ? 1 : 0;
                        if (mbk == 0 && mj == 1) ms = 0;
                        else if (mbk >= 1 && mbk <= mnb) macc[mbk-1] = mj[0];
                        else if (mbk == mnb + 1) begin
                            mpend = 1;
                            mword = {~mj[0], (mnb == 9) ? macc[8] : 1'b0, macc[7:0]};
                            ms = 0;
                        end
                    end
                    mpos++;
                end
            end
        end
    end

    // per-cycle comparison against the model (R4, R5, R6, R2, R3)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(rx_avail == (mq.size() != 0), "R4 model avail", rx_avail, mq.size() != 0);
            chk(rx_ovr == m_ovr, "R6 model ovr", rx_ovr, m_ovr);
            if (mq.size() != 0) begin
                chk(rx_data == mq[0][7:0], "R2 model data", rx_data, mq[0][7:0]);
                chk(rx_bit9 == mq[0][8], "R3 model bit9", rx_bit9, mq[0][8]);
                chk(rx_ferr == mq[0][9], "R5 model ferr", rx_ferr, mq[0][9]);
            end
        end
    end

    task automatic send(input int val, input int nb, input bit stopv, input int flip);
        bit s[$];
        for (int i = 0; i < 16; i++) s.push_back(1'b0);
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 16; i++) s.push_back(((val >> b) & 1) == 1);
        for (int i = 0; i < 16; i++) s.push_back(stopv);
        for (int i = 0; i < 16; i++) s.push_back(1'b1);
        if (flip >= 0) s[flip] = ~s[flip];
        foreach (s[i]) sampq.push_back(s[i]);
    endtask

    task automatic drain();
        while (sampq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic read_check(input int d, input bit b9, input bit fe, input string req);
        chk(rx_avail == 1'b1, {req, " avail"}, rx_avail, 1);
        chk(rx_data == d[7:0], {req, " data"}, rx_data, d[7:0]);
        chk(rx_bit9 == b9, {req, " bit9"}, rx_bit9, b9);
        chk(rx_ferr == fe, {req, " ferr"}, rx_ferr, fe);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; rx_en = 1'b0; nine_bit = 1'b0; rd_pop = 1'b0;
        repeat (5) @(negedge clk);
        chk(rx_avail == 1'b0, "R9 reset avail", rx_avail, 0);
        chk(rx_ovr == 1'b0, "R9 reset ovr", rx_ovr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;

        // R2: glitch on one voting sample of data bit 3
        send(8'hA5, 8, 1'b1, 16 * 4 + 7);
        drain();
        read_check(8'hA5, 1'b0, 1'b0, "R2 voted data");

        // R5: bad stop then good frame, status per entry
        send(8'h3C, 8, 1'b0, -1);
        send(8'h81, 8, 1'b1, -1);
        drain();
        read_check(8'h3C, 1'b0, 1'b1, "R5 head ferr");
        read_check(8'h81, 1'b0, 1'b0, "R5 next ferr");
        chk(rx_avail == 1'b0, "R4 empty after reads", rx_avail, 0);
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
        chk(rx_avail == 1'b0, "R4 pop on empty", rx_avail, 0);

        // R1: false start, then a start with one high vote sample
        for (int i = 0; i < 3; i++) sampq.push_back(1'b0);
        for (int i = 0; i < 24; i++) sampq.push_back(1'b1);
        drain();
        chk(rx_avail == 1'b0, "R1 false start", rx_avail, 0);
        send(8'h5A, 8, 1'b1, 8);
        drain();
        read_check(8'h5A, 1'b0, 1'b0, "R1 start vote");

        // R3: nine-bit frames
        nine_bit = 1'b1;
        send(9'h1C3, 9, 1'b1, -1);
        send(9'h042, 9, 1'b1, -1);
        drain();
        read_check(8'hC3, 1'b1, 1'b0, "R3 bit9 one");
        read_check(8'h42, 1'b0, 1'b0, "R3 bit9 zero");
        nine_bit = 1'b0;

        // R6/R7/R8: overrun, lockout, clear by disable
        send(8'h11, 8, 1'b1, -1);
        send(8'h22, 8, 1'b1, -1);
        send(8'h33, 8, 1'b1, -1);
        drain();
        chk(rx_ovr == 1'b1, "R6 overrun set", rx_ovr, 1);
        chk(rx_data == 8'h11, "R6 head kept", rx_data, 8'h11);
        send(8'h44, 8, 1'b1, -1);
        drain();
        chk(rx_ovr == 1'b1, "R7 overrun sticky", rx_ovr, 1);
        rx_en = 1'b0; @(negedge clk);
        rx_en = 1'b1; @(negedge clk);
        chk(rx_ovr == 1'b0, "R8 overrun cleared", rx_ovr, 0);
        chk(rx_data == 8'h11, "R8 queue kept", rx_data, 8'h11);
        read_check(8'h11, 1'b0, 1'b0, "R6 first kept");
        read_check(8'h22, 1'b0, 1'b0, "R6 second kept");
        chk(rx_avail == 1'b0, "R7 locked-out word absent", rx_avail, 0);

        // R8: frame while disabled is ignored
        rx_en = 1'b0;
        send(8'h77, 8, 1'b1, -1);
        drain();
        chk(rx_avail == 1'b0, "R8 disabled ignored", rx_avail, 0);
        rx_en = 1'b1;
        @(negedge clk);
        send(8'h66, 8, 1'b1, -1);
        drain();
        read_check(8'h66, 1'b0, 1'b0, "R8 resumed");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule